// File: doc/BRIEF.md
# Serial Debug Instruction-Injection Target

This block is the target end of a two-wire debug port made of a host-driven clock line and a shared data line. The host sends 4-bit command codes, least significant bit first. An execute command is followed by a 24-bit instruction word. The block hands that word to the core as a bus with a one-cycle valid strobe. A readout command is followed by a fixed idle stretch. After it, the block turns the data line around and drives a 16-bit visibility value back to the host.

Both serial lines are brought into the fast system clock through a synchroniser. The block acts on edges detected in that domain, so the serial clock must run well below the system clock. After reset, the first frame is an implied execute command that lasts longer than normal and produces an all-zero no-operation word. The core can run a word while the host is already shifting in the next code, because the strobe fires on the edge that completes the word.

Top module: `dbg_inject_target`

## Requirements
- R1: While reset is asserted and right after it, `instr_valid`, `ser_oe` and `ser_dout` are 0.
- R2: The first 9 serial rising edges after reset form an implied execute frame whatever the data. On the 9th edge the block produces exactly one strobe with `instr_word` = 24'h000000, and no strobe comes before it.
- R3: The 24 bits that follow the start-up frame are captured least significant bit first and presented with one strobe on the 24th rising edge.
- R4: `instr_valid` is never high for more than one system clock cycle.
- R5: A code of 4'b0000, with bit 0 sent first, selects execute. The next 24 bits, least significant bit first, appear on `instr_word` with one strobe. The rising edge after the 24th bit is bit 0 of the next command code.
- R6: A code of 4'b0001 selects readout. After 8 idle rising edges, the 16 bits of `vis_data` leave on `ser_dout` with bit 0 first. Each bit changes only after a falling serial-clock edge and is held through the following rising edge.
- R7: `ser_oe` stays 0 while a code, an instruction or the idle stretch is received. It becomes 1 at the falling edge that ends the idle stretch and stays 1 for all 16 readout bits.
- R8: After the 16th readout bit, `ser_oe` and the last bit stay driven until the next serial rising edge, and then `ser_oe` drops. The data sampled on that edge is bit 0 of the next command code.
- R9: Any code other than 4'b0000 or 4'b0001 takes exactly 4 rising edges and has no effect: no strobe, `ser_oe` stays 0, and the next edge starts a new code.
- R10: `vis_data` is captured on the last idle rising edge. Changes to it during the 16 readout bits do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data line, input side |
| ser_dout | output | 1 | Serial data line, output side |
| ser_oe | output | 1 | Output enable for the serial data line |
| vis_data | input | 16 | Visibility value returned by readout |
| instr_word | output | 24 | Instruction word for the core |
| instr_valid | output | 1 | One-cycle strobe marking `instr_word` valid |

## Verification
A bit counter that has slipped shows up quickly at the ports. On an execute frame the strobe moves to the wrong serial edge and the instruction word arrives shifted, so a misplaced frame boundary appears no later than the end of the next frame. A wrong phase shows up as `ser_oe` asserting during idle or command bits, or as readout data offset by one or more positions. The line-turnaround timing is checked at the single rising edge after the last readout bit, which is where an early or late release of the line shows.

// File: rtl/dbgi_pkg.sv
package dbgi_pkg;

   typedef enum logic [2:0] {
      PH_BOOT = 3'd0,
      PH_CMD  = 3'd1,
      PH_LOAD = 3'd2,
      PH_WAIT = 3'd3,
      PH_SEND = 3'd4
   } phase_t;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/dbgi_sync.sv
module dbgi_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dbgi_rx.sv
module dbgi_rx #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] nxt
);

   logic [W-1:0] sh;

   // LSB-first: new bit enters at the top, so after W edges bit 0 sits at index 0
   always_comb nxt = {din, sh[W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sh <= '0;
      else if (en) sh <= nxt;
   end

endmodule

// File: rtl/dbgi_tx.sv
module dbgi_tx #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   output logic         dout
);

   logic [W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         dout <= 1'b0;
      end else if (load) begin
         sh <= load_val;
      end else if (shift) begin
         dout <= sh[0];
         sh   <= {1'b0, sh[W-1:1]};
      end
   end

endmodule

// File: rtl/dbgi_ctrl.sv
module dbgi_ctrl
   import dbgi_pkg::*;
#(
   parameter int               CMD_W     = 4,
   parameter int               INSTR_W   = 24,
   parameter int               VIS_W     = 16,
   parameter int               IDLE_CLKS = 8,
   parameter int               BOOT_CLKS = 9,
   parameter logic [CMD_W-1:0] EXEC_CODE = '0,
   parameter logic [CMD_W-1:0] READ_CODE = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rise,
   input  logic               fall,
   input  logic [INSTR_W-1:0] rx_nxt,
   output phase_t             phase,
   output logic [INSTR_W-1:0] word,
   output logic               valid,
   output logic               oe,
   output logic               tx_load,
   output logic               tx_shift
);

   localparam int MAXC  = max4(CMD_W, INSTR_W, IDLE_CLKS, max4(VIS_W, BOOT_CLKS, 1, 1));
   localparam int CNT_W = $clog2(MAXC + 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;
   logic [CMD_W-1:0] code;
   logic             hit;
   phase_t           nxt_ph;

   always_comb begin
      case (phase)
         PH_BOOT: lim = CNT_W'(BOOT_CLKS - 1);
         PH_CMD:  lim = CNT_W'(CMD_W - 1);
         PH_LOAD: lim = CNT_W'(INSTR_W - 1);
         PH_WAIT: lim = CNT_W'(IDLE_CLKS - 1);
         default: lim = CNT_W'(VIS_W - 1);
      endcase
   end

   assign hit  = rise && (cnt == lim);
   assign code = rx_nxt[INSTR_W-1 -: CMD_W];

   always_comb begin
      nxt_ph = phase;
      if (hit) begin
         case (phase)
            PH_BOOT: nxt_ph = PH_LOAD;
            PH_CMD: begin
               if (code == EXEC_CODE)      nxt_ph = PH_LOAD;
               else if (code == READ_CODE) nxt_ph = PH_WAIT;
               else                        nxt_ph = PH_CMD;
            end
            PH_LOAD: nxt_ph = PH_CMD;
            PH_WAIT: nxt_ph = PH_SEND;
            default: nxt_ph = PH_CMD;
         endcase
      end
   end

   assign tx_load  = hit && (phase == PH_WAIT);
   assign tx_shift = fall && (phase == PH_SEND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_BOOT;
         cnt   <= '0;
      end else if (rise) begin
         phase <= nxt_ph;
         cnt   <= hit ? '0 : cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         word  <= '0;
      end else begin
         valid <= hit && ((phase == PH_BOOT) || (phase == PH_LOAD));
         if (hit && (phase == PH_BOOT))      word <= '0;
         else if (hit && (phase == PH_LOAD)) word <= rx_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          oe <= 1'b0;
      else if (rise && phase != PH_SEND)   oe <= 1'b0;
      else if (tx_shift)                   oe <= 1'b1;
   end

endmodule

// File: rtl/dbg_inject_target.sv
module dbg_inject_target
   import dbgi_pkg::*;
#(
   parameter int CMD_W       = 4,
   parameter int INSTR_W     = 24,
   parameter int VIS_W       = 16,
   parameter int IDLE_CLKS   = 8,
   parameter int BOOT_CLKS   = 9,
   parameter int SYNC_STAGES = 2,
   parameter int CODE_EXEC   = 0,
   parameter int CODE_READ   = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_clk,
   input  logic               ser_din,
   output logic               ser_dout,
   output logic               ser_oe,
   input  logic [VIS_W-1:0]   vis_data,
   output logic [INSTR_W-1:0] instr_word,
   output logic               instr_valid
);

   localparam logic [CMD_W-1:0] EXEC_CODE = CMD_W'(CODE_EXEC);
   localparam logic [CMD_W-1:0] READ_CODE = CMD_W'(CODE_READ);

   initial begin : p_param_chk
      assert (SYNC_STAGES >= 2) else $fatal(1, "SYNC_STAGES must be at least 2");
      assert (INSTR_W >= CMD_W) else $fatal(1, "INSTR_W must cover CMD_W");
      assert (CMD_W >= 1 && VIS_W >= 1 && IDLE_CLKS >= 1 && BOOT_CLKS >= 1)
         else $fatal(1, "frame lengths must be positive");
      assert (EXEC_CODE != READ_CODE) else $fatal(1, "command codes must differ");
   end

   logic [1:0]         sync_q;
   logic               clk_prev;
   logic               ser_rise;
   logic               ser_fall;
   logic [INSTR_W-1:0] rx_nxt;
   phase_t             phase;
   logic               tx_load;
   logic               tx_shift;

   dbgi_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_clk, ser_din}),
      .q     (sync_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_prev <= 1'b0;
      else        clk_prev <= sync_q[1];
   end

   assign ser_rise = sync_q[1] & ~clk_prev;
   assign ser_fall = ~sync_q[1] & clk_prev;

   dbgi_rx #(.W(INSTR_W)) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ser_rise),
      .din   (sync_q[0]),
      .nxt   (rx_nxt)
   );

   dbgi_ctrl #(
      .CMD_W     (CMD_W),
      .INSTR_W   (INSTR_W),
      .VIS_W     (VIS_W),
      .IDLE_CLKS (IDLE_CLKS),
      .BOOT_CLKS (BOOT_CLKS),
      .EXEC_CODE (EXEC_CODE),
      .READ_CODE (READ_CODE)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise     (ser_rise),
      .fall     (ser_fall),
      .rx_nxt   (rx_nxt),
      .phase    (phase),
      .word     (instr_word),
      .valid    (instr_valid),
      .oe       (ser_oe),
      .tx_load  (tx_load),
      .tx_shift (tx_shift)
   );

   dbgi_tx #(.W(VIS_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tx_load),
      .load_val (vis_data),
      .shift    (tx_shift),
      .dout     (ser_dout)
   );

endmodule

// File: rtl/dbgi_chk.sv
module dbgi_chk
   import dbgi_pkg::*;
#(
   parameter int INSTR_W = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rise,
   input logic               fall,
   input phase_t             phase,
   input logic               valid,
   input logic [INSTR_W-1:0] word,
   input logic               oe,
   input logic               sdo
);

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid); // R4

   AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $past(rise)); // R3

   AST_BOOT_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && $past(phase) == PH_BOOT) |-> (word == '0)); // R2

   AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_BOOT || phase == PH_LOAD || phase == PH_WAIT) |-> !oe); // R7

   AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> ($past(fall) && $past(phase) == PH_SEND)); // R7

   AST_OE_OFF_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe) |-> $past(rise)); // R8

   AST_DOUT_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(fall) |-> $stable(sdo)); // R6

endmodule

bind dbg_inject_target dbgi_chk #(.INSTR_W(INSTR_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .rise  (ser_rise),
   .fall  (ser_fall),
   .phase (phase),
   .valid (instr_valid),
   .word  (instr_word),
   .oe    (ser_oe),
   .sdo   (ser_dout)
);

// File: tb/dbg_inject_target_tb.sv
module dbg_inject_target_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_din = 1'b0;
   logic        ser_dout;
   logic        ser_oe;
   logic [15:0] vis_data = '0;
   logic [23:0] instr_word;
   logic        instr_valid;

   always #4 clk = ~clk; // 125 MHz

   dbg_inject_target u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .ser_clk     (ser_clk),
      .ser_din     (ser_din),
      .ser_dout    (ser_dout),
      .ser_oe      (ser_oe),
      .vis_data    (vis_data),
      .instr_word  (instr_word),
      .instr_valid (instr_valid)
   );

   int          checks = 0;
   int          fails = 0;
   int          pulses = 0;
   int          run_len = 0;
   int          max_run = 0;
   logic [23:0] last_word = '0;
   bit          done = 0;

   always @(posedge clk) begin
      if (instr_valid) begin
         pulses    = pulses + 1;
         last_word = instr_word;
         run_len   = run_len + 1;
         if (run_len > max_run) max_run = run_len;
      end else begin
         run_len = 0;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one serial clock: data set, sample line before the rising edge, high half, fall
   task automatic tick(input logic b, output logic s, output logic o);
      @(negedge clk);
      ser_din = b;
      repeat (4) @(negedge clk);
      s = ser_dout;
      o = ser_oe;
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
   endtask

   task automatic send_bits(input logic [23:0] v, input int n);
      logic s, o;
      for (int k = 0; k < n; k++) tick(v[k], s, o);
   endtask

   task automatic do_reset();
      rst_n   = 1'b0;
      ser_clk = 1'b0;
      ser_din = 1'b0;
      repeat (5) @(negedge clk);
      check(instr_valid == 0 && ser_oe == 0 && ser_dout == 0, "R1",
            {instr_valid, ser_oe, ser_dout}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(instr_valid == 0 && ser_oe == 0 && ser_dout == 0, "R1",
            {instr_valid, ser_oe, ser_dout}, 0);
   endtask

   task automatic boot_frame();
      int p0;
      p0 = pulses;
      send_bits(24'hFFFFFF, 8);
      check(pulses == p0, "R2 no early strobe", pulses - p0, 0);
      send_bits(24'h1, 1);
      repeat (2) @(negedge clk);
      check(pulses == p0 + 1, "R2 strobe count", pulses - p0, 1);
      check(last_word == 24'h0, "R2 word", last_word, 0);
   endtask

   // kind: 0 execute, 1 readout, 2 unknown code; payload is the word or the visibility value
   localparam int NV = 9;
   localparam logic [29:0] VEC [NV] = '{
      {2'd0, 4'h0, 24'h123456},
      {2'd1, 4'h1, 24'h00A5C3},
      {2'd2, 4'h5, 24'h000000},
      {2'd0, 4'h0, 24'h00FFFF},
      {2'd1, 4'h1, 24'h008001},
      {2'd2, 4'hF, 24'h000000},
      {2'd0, 4'h0, 24'h800001},
      {2'd1, 4'h1, 24'h007E18},
      {2'd0, 4'h0, 24'hABCDEF}
   };

   initial begin : p_main
      logic [1:0]  kind;
      logic [3:0]  code;
      logic [23:0] pay;
      logic        s, o;
      int          p0;

      do_reset();
      boot_frame();

      // R3: first word after the start-up frame
      p0 = pulses;
      send_bits(24'h5A0F3C, 24);
      repeat (2) @(negedge clk);
      check(pulses == p0 + 1, "R3 strobe count", pulses - p0, 1);
      check(last_word == 24'h5A0F3C, "R3 word", last_word, 24'h5A0F3C);

      for (int i = 0; i < NV; i++) begin
         kind = VEC[i][29:28];
         code = VEC[i][27:24];
         pay  = VEC[i][23:0];
         p0   = pulses;
         if (kind == 2'd1) vis_data = pay[15:0];
         send_bits({20'h0, code}, 4);
         if (kind == 2'd0) begin
            send_bits(pay, 24);
            repeat (2) @(negedge clk);
            check(pulses == p0 + 1, "R5 strobe count", pulses - p0, 1);
            check(last_word == pay, "R5 word", last_word, pay);
         end else if (kind == 2'd1) begin
            for (int k = 0; k < 8; k++) begin
               tick(1'b0, s, o);
               check(o == 1'b0, "R7 idle oe", o, 0);
            end
            for (int k = 0; k < 16; k++) begin
               if (k == 8) vis_data = ~pay[15:0]; // R10
               tick(1'b0, s, o);
               check(o == 1'b1, "R7 readout oe", o, 1);
               check(s == pay[k], "R6 R10 readout bit", s, pay[k]);
            end
            check(pulses == p0, "R6 no strobe", pulses - p0, 0);
         end else begin
            repeat (2) @(negedge clk);
            check(pulses == p0, "R9 no strobe", pulses - p0, 0);
            check(ser_oe == 1'b0, "R9 oe", ser_oe, 0);
         end
      end

      // R8: line held after readout until the next rising edge, which is code bit 0
      vis_data = 16'hBEEF;
      send_bits(24'h1, 4);
      send_bits(24'h0, 8);
      for (int k = 0; k < 16; k++) tick(1'b0, s, o);
      repeat (20) @(negedge clk);
      check(ser_oe == 1'b1, "R8 oe held", ser_oe, 1);
      check(ser_dout == 1'b1, "R8 last bit held", ser_dout, 1);
      ser_din = 1'b0;
      ser_clk = 1'b1;
      repeat (5) @(negedge clk);
      check(ser_oe == 1'b0, "R8 oe released", ser_oe, 0);
      ser_clk = 1'b0;
      p0 = pulses;
      send_bits(24'h0, 3);
      send_bits(24'h000042, 24);
      repeat (2) @(negedge clk);
      check(pulses == p0 + 1 && last_word == 24'h000042, "R8 next code is execute",
            last_word, 24'h000042);

      check(max_run == 1, "R4 strobe width", max_run, 1);

      // reset in mid-frame restarts with the start-up frame
      send_bits(24'h0, 4);
      send_bits(24'h3FF, 10);
      do_reset();
      boot_frame();
      p0 = pulses;
      send_bits(24'hC0FFEE, 24);
      repeat (2) @(negedge clk);
      check(last_word == 24'hC0FFEE && pulses == p0 + 1, "R3 after reset", last_word, 24'hC0FFEE);
      check(max_run == 1, "R4 strobe width", max_run, 1);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : p_watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule